// File: doc/BRIEF.md
# Radio Command SPI Sequencer

This block lets on-chip logic run transactions against an external radio transceiver over a four-wire SPI link. The transceiver reports through a BUSY line when it can take a new frame. A request names a transaction kind, an opcode, a 16-bit address (or an 8-bit offset taken from its low byte) and a byte count. The sequencer builds the header for that kind. It then moves the payload: write bytes come from a valid/ready input stream, and read bytes leave on a valid/ready output stream. It keeps chip select low for the whole frame and gates the frame on BUSY, both before the frame starts and after it ends.

Back-pressure works the same way in both directions. A write byte is taken only on a cycle where `wr_valid` and `wr_ready` are both high. While the stream is empty, the frame pauses with SCLK low and chip select held low. A read byte sits on `rd_data` with `rd_valid` high until `rd_ready` takes it, and the next byte is not clocked until then. Requests use the same handshake, and `req_ready` is high only while the block is idle. The `done` pulse marks the end of each transaction.

Top module: `radio_spi_seq`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is high, and both `done` and `rd_valid` are low.
- R2: Every byte is 8 bits, sent MSB first in SPI mode 0. SCLK idles low and MOSI changes only while SCLK is low. Chip select stays low for the whole frame, and the frame carries exactly 8 SCLK rising edges per byte.
- R3: Kind 0 (command write) sends the opcode and then exactly N bytes taken in order from the write stream. With N=0 only the opcode is sent. Kind 7 behaves the same as kind 0.
- R4: Kind 1 (command read) sends the opcode, one 0x00 dummy byte and then N 0x00 bytes. The MISO byte captured during each of those N bytes is delivered in order on the read stream.
- R5: Kinds 2 and 3 (register write/read) send the opcode, then address bits 15:8, then bits 7:0. A write then sends N stream bytes. A read then sends one 0x00 dummy byte and N 0x00 bytes, and returns the MISO bytes of those N positions.
- R6: Kinds 4 and 5 (buffer write/read) send the opcode and then address bits 7:0 as the offset. After that they follow the same write or read data rules as R5.
- R7: For a normal transaction, chip select does not fall while the synchronised BUSY is high. The frame starts only after BUSY has been low for the two synchroniser cycles.
- R8: After the frame, `done` waits for the synchronised BUSY to be low. The exception is an opcode equal to SLEEP_OP, where `done` follows the frame without checking BUSY.
- R9: Kind 6 (wake-up) ignores `req_opcode` and sends STATUS_OP followed by 0x00. It starts the frame without checking BUSY, then waits for BUSY low before `done`.
- R10: `req_nobusy` set with kind 2 or 3 skips both BUSY waits. With any other kind the flag has no effect.
- R11: `done` is high for exactly one cycle per transaction. A request offered while `req_ready` is low is ignored and starts no frame.
- R12: Write bytes are consumed only on a valid/ready handshake. A read byte holds `rd_valid` and `rd_data` steady until `rd_ready`, no SCLK edge occurs while it waits, and `done` comes only after the last read byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_in | input | 1 | Transceiver BUSY line (asynchronous) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_kind | input | 3 | Transaction kind code (see R3 to R9) |
| req_nobusy | input | 1 | Skip BUSY waits for register kinds |
| req_opcode | input | 8 | Opcode byte |
| req_addr | input | 16 | Register address; bits 7:0 serve as buffer offset |
| req_len | input | LEN_W (8) | Payload byte count N |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle if valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong header index or kind decode is visible at the pins within the first few bytes. It shows up as a shifted or missing address byte, a missing dummy byte, or a byte count that differs from the expected frame length when chip select rises. A corrupted payload counter or a broken stall path shows up as extra or missing SCLK edges, or as read bytes that are lost, repeated or out of order on the stream. A broken BUSY gate shows up as chip select falling, or `done` pulsing, while the modelled BUSY line is still high. That fault is seen on the first transaction that holds BUSY.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [2:0] {
    K_CMD_WR = 3'd0,
    K_CMD_RD = 3'd1,
    K_REG_WR = 3'd2,
    K_REG_RD = 3'd3,
    K_BUF_WR = 3'd4,
    K_BUF_RD = 3'd5,
    K_WAKE   = 3'd6,
    K_RSVD   = 3'd7
  } xfer_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_HDR,
    S_DATA,
    S_FIN,
    S_POST
  } seq_state_e;

  localparam int HDR_MAX = 4;

endpackage

// File: rtl/seq_busy_sync.sv
module seq_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  // Reset to 1: the transceiver is treated as busy until it is seen idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/seq_spi_byte.sv
module seq_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic          act, sclk_q, done_q;
  logic [7:0]    sh, rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; nbit <= '0; act <= 1'b0; sclk_q <= 1'b0;
      done_q <= 1'b0; sh <= '0; rx <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sh <= tx_byte; act <= 1'b1; cnt <= '0; nbit <= '0; sclk_q <= 1'b0;
      end else if (act) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;                 // rising edge: sample
            rx     <= {rx[6:0], miso};
          end else begin
            sclk_q <= 1'b0;                 // falling edge: shift out next bit
            sh     <= {sh[6:0], 1'b0};
            if (nbit == 3'd7) begin
              act    <= 1'b0;
              done_q <= 1'b1;
            end else begin
              nbit <= nbit + 3'd1;
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh[7];
  assign done    = done_q;
  assign rx_byte = rx;

  // MOSI may only move while SCLK is low (mode 0).
  assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sh[7]));
  // A byte ends with SCLK low.
  assert_byte_ends_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !sclk_q);
endmodule

// File: rtl/seq_hdr_build.sv
module seq_hdr_build
  import radio_seq_pkg::*;
#(
  parameter logic [7:0] SLEEP_OP  = 8'h84,
  parameter logic [7:0] STATUS_OP = 8'hC0
) (
  input  logic [2:0]               kind,
  input  logic                     nobusy,
  input  logic [7:0]               opcode,
  input  logic [15:0]              addr,
  output logic [HDR_MAX-1:0][7:0]  hdr,
  output logic [2:0]               hdr_cnt,
  output logic                     is_read,
  output logic                     has_data,
  output logic                     skip_pre,
  output logic                     skip_post
);
  always_comb begin
    hdr       = '0;
    hdr[0]    = opcode;
    hdr_cnt   = 3'd1;
    is_read   = 1'b0;
    has_data  = 1'b1;
    skip_pre  = 1'b0;
    skip_post = (opcode == SLEEP_OP);
    unique case (xfer_kind_e'(kind))
      K_CMD_RD: begin
        hdr_cnt = 3'd2; is_read = 1'b1;
      end
      K_REG_WR, K_REG_RD: begin
        hdr[1]  = addr[15:8];
        hdr[2]  = addr[7:0];
        hdr_cnt = (kind == K_REG_RD) ? 3'd4 : 3'd3;
        is_read = (kind == K_REG_RD);
        if (nobusy) begin
          skip_pre  = 1'b1;
          skip_post = 1'b1;
        end
      end
      K_BUF_WR, K_BUF_RD: begin
        hdr[1]  = addr[7:0];
        hdr_cnt = (kind == K_BUF_RD) ? 3'd3 : 3'd2;
        is_read = (kind == K_BUF_RD);
      end
      K_WAKE: begin
        hdr[0]    = STATUS_OP;
        hdr_cnt   = 3'd2;
        has_data  = 1'b0;
        skip_pre  = 1'b1;
        skip_post = 1'b0;
      end
      default: ;  // command write and the spare code share one framing
    endcase
  end
endmodule

// File: rtl/radio_spi_seq.sv
module radio_spi_seq
  import radio_seq_pkg::*;
#(
  parameter int         HALF_DIV  = 2,
  parameter int         LEN_W     = 8,
  parameter int         SYNC_STG  = 2,
  parameter logic [7:0] SLEEP_OP  = 8'h84,
  parameter logic [7:0] STATUS_OP = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_in,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic             req_nobusy,
  input  logic [7:0]       req_opcode,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  seq_state_e              state;
  logic [HDR_MAX-1:0][7:0] hdr_q, b_hdr;
  logic [2:0]              hdr_n, hidx, b_cnt;
  logic [LEN_W-1:0]        len_q, dcnt;
  logic                    rd_mode, skip_post_q, launched;
  logic                    rd_valid_q, done_q;
  logic [7:0]              rd_data_q;
  logic                    b_rd, b_data, b_skip_pre, b_skip_post;
  logic                    busy_s, eng_start, eng_done;
  logic [7:0]              eng_tx, eng_rx;

  seq_busy_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(busy_in), .q_sync(busy_s));

  seq_hdr_build #(.SLEEP_OP(SLEEP_OP), .STATUS_OP(STATUS_OP)) u_hdr (
    .kind(req_kind), .nobusy(req_nobusy), .opcode(req_opcode), .addr(req_addr),
    .hdr(b_hdr), .hdr_cnt(b_cnt), .is_read(b_rd), .has_data(b_data),
    .skip_pre(b_skip_pre), .skip_post(b_skip_post));

  seq_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done),
    .rx_byte(eng_rx));

  // Byte launch: headers freely, data gated by the streams.
  always_comb begin
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    wr_ready  = (state == S_DATA) && !rd_mode && !launched;
    if (state == S_HDR) begin
      eng_start = !launched;
      eng_tx    = hdr_q[hidx[1:0]];
    end else if (state == S_DATA) begin
      if (rd_mode) eng_start = !launched && !rd_valid_q;
      else begin
        eng_start = wr_ready && wr_valid;
        eng_tx    = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; hdr_q <= '0; hdr_n <= 3'd1; hidx <= '0;
      len_q <= '0; dcnt <= '0; rd_mode <= 1'b0; skip_post_q <= 1'b0;
      launched <= 1'b0; rd_valid_q <= 1'b0; rd_data_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (eng_start)     launched <= 1'b1;
      else if (eng_done) launched <= 1'b0;
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          hdr_q       <= b_hdr;
          hdr_n       <= b_cnt;
          rd_mode     <= b_rd;
          len_q       <= b_data ? req_len : '0;
          skip_post_q <= b_skip_post;
          hidx        <= '0;
          dcnt        <= '0;
          state       <= b_skip_pre ? S_HDR : S_PRE;
        end
        S_PRE: if (!busy_s) state <= S_HDR;
        S_HDR: if (eng_done) begin
          if (hidx == hdr_n - 3'd1) state <= (len_q == '0) ? S_FIN : S_DATA;
          else                      hidx  <= hidx + 3'd1;
        end
        S_DATA: if (eng_done) begin
          if (rd_mode) begin
            rd_data_q  <= eng_rx;
            rd_valid_q <= 1'b1;
          end
          if (dcnt == len_q - LEN_ONE) state <= S_FIN;
          else                         dcnt  <= dcnt + LEN_ONE;
        end
        S_FIN: if (!rd_valid_q) begin
          if (skip_post_q) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_POST;
          end
        end
        S_POST: if (!busy_s) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign spi_cs_n  = !((state == S_HDR) || (state == S_DATA));
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign done      = done_q;

  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  assert_pre_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE && busy_s) |=> spi_cs_n);
  assert_accept_leaves_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  assert_rd_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_sclk);
endmodule

// File: tb/test_radio_spi_seq.sv
module test_radio_spi_seq;
  localparam logic [7:0] SLEEP_OP  = 8'h84;
  localparam logic [7:0] STATUS_OP = 8'hC0;
  localparam int POSTK = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_nobusy = 0, wr_valid = 0, rd_ready = 0;
  logic [2:0] req_kind = 0;
  logic [7:0] req_opcode = 0, wr_data = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_len = 0;
  logic req_ready, wr_ready, rd_valid, done, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic [7:0] rd_data;
  logic busy_in, hold = 0, auto_b = 1;

  int n_chk = 0, n_bad = 0;
  int sbits = 0, last_bits = 0, frames = 0;
  int post_cnt = 0, done_cnt = 0, db_cnt = 0, cb_cnt = 0, sclk_bad = 0, cyc = 0;
  logic cs_prev = 1'b1;
  logic [7:0] mlog [0:63];
  logic [7:0] exp_b [0:63];
  logic [7:0] rd_got [0:63];
  int exp_n, hdr_n, rd_n;

  always #10 clk = ~clk;   // 50 MHz

  radio_spi_seq i_radio_spi_seq (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_nobusy(req_nobusy),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  function automatic logic [7:0] resp(int k);
    return 8'((k * 37 + 90) & 255);
  endfunction
  function automatic logic resp_bit(int b);
    logic [7:0] v = resp(b / 8);
    return v[7 - (b % 8)];
  endfunction
  function automatic logic [7:0] wdat(int seed, int i);
    return 8'((seed + i * 29 + 3) & 255);
  endfunction

  assign busy_in  = hold | (auto_b & ~spi_cs_n) | (post_cnt != 0);
  assign spi_miso = spi_cs_n ? 1'b0 : resp_bit(sbits);

  // Transceiver model: MSB-first capture on rising SCLK, frame closed on CS rise.
  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      last_bits = sbits; frames = frames + 1; sbits = 0;
    end else if (sbits < 512) begin
      mlog[sbits / 8] = {mlog[sbits / 8][6:0], spi_mosi};
      sbits = sbits + 1;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done) begin
      done_cnt = done_cnt + 1;
      if (hold || post_cnt != 0) db_cnt = db_cnt + 1;
    end
    if (cs_prev && !spi_cs_n) begin
      if (hold) cb_cnt = cb_cnt + 1;
      if (spi_sclk) sclk_bad = sclk_bad + 1;
    end
    if (!cs_prev && spi_cs_n) post_cnt = POSTK;
    else if (post_cnt != 0) post_cnt = post_cnt - 1;
    cs_prev = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic string tag_of(int kind);
    case (kind)
      0, 7: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic build_exp(int kind, logic [7:0] op, logic [15:0] addr, int len);
    int p = 0;
    exp_b[p++] = (kind == 6) ? STATUS_OP : op;
    case (kind)
      1: exp_b[p++] = 8'h00;
      2: begin exp_b[p++] = addr[15:8]; exp_b[p++] = addr[7:0]; end
      3: begin exp_b[p++] = addr[15:8]; exp_b[p++] = addr[7:0]; exp_b[p++] = 8'h00; end
      4: exp_b[p++] = addr[7:0];
      5: begin exp_b[p++] = addr[7:0]; exp_b[p++] = 8'h00; end
      6: exp_b[p++] = 8'h00;
      default: ;
    endcase
    hdr_n = p;
    if (kind != 6)
      for (int i = 0; i < len; i++)
        exp_b[p++] = (kind == 1 || kind == 3 || kind == 5) ? 8'h00 : wdat(op, i);
    exp_n = p;
  endtask

  task automatic issue(int kind, logic nb, logic [7:0] op, logic [15:0] addr, int len);
    @(negedge clk);
    req_kind = 3'(kind); req_nobusy = nb; req_opcode = op;
    req_addr = addr; req_len = 8'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic feed_wr(int seed, int n, bit thr);
    int i = 0;
    bit acc = 0;
    while (1) begin
      @(negedge clk);
      if (acc) i++;
      if (i == n) begin wr_valid = 1'b0; break; end
      wr_data  = wdat(seed, i);
      wr_valid = thr ? (cyc % 3 != 0) : 1'b1;
      acc      = wr_valid && wr_ready;
    end
  endtask

  task automatic sink_rd(int n, bit thr, int delay);
    rd_n = 0;
    if (delay > 0 && n > 0) begin
      int b0;
      logic [7:0] d0;
      rd_ready = 1'b0;
      do @(negedge clk); while (!rd_valid);
      b0 = sbits; d0 = rd_data;
      repeat (delay) @(negedge clk);
      chk(sbits == b0 && rd_valid && rd_data == d0, "R12", "stall on pending read byte",
          sbits, b0);
    end
    while (rd_n < n) begin
      @(negedge clk);
      rd_ready = thr ? (cyc % 3 != 1) : 1'b1;
      if (rd_valid && rd_ready) rd_got[rd_n++] = rd_data;
    end
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run_txn(int kind, logic nb, logic [7:0] op, logic [15:0] addr, int len,
                         bit thr, int rdel, int exp_cb, int exp_db);
    int f0 = frames, d0 = done_cnt, db0 = db_cnt, cb0 = cb_cnt, sb0 = sclk_bad;
    int nbad = 0, fb = -1;
    bit is_rd = (kind == 1 || kind == 3 || kind == 5);
    bit is_wr = (kind == 0 || kind == 2 || kind == 4 || kind == 7);
    string t = tag_of(kind);
    build_exp(kind, op, addr, len);
    fork
      issue(kind, nb, op, addr, len);
      if (is_wr && len > 0) feed_wr(op, len, thr);
      if (is_rd) sink_rd(len, thr, rdel);
      wait_done();
    join
    @(negedge clk);
    chk(frames - f0 == 1, t, "frame count", frames - f0, 1);
    chk(last_bits == exp_n * 8, "R2", "SCLK rising edges in frame", last_bits, exp_n * 8);
    chk(sclk_bad == sb0, "R2", "SCLK high at CS fall", sclk_bad - sb0, 0);
    for (int j = 0; j < exp_n; j++)
      if (mlog[j] !== exp_b[j]) begin nbad++; if (fb < 0) fb = j; end
    if (fb < 0) chk(1, t, "MOSI bytes", 0, 0);
    else chk(0, t, "MOSI byte mismatch", int'(mlog[fb]), int'(exp_b[fb]));
    if (is_rd) begin
      nbad = 0; fb = -1;
      for (int j = 0; j < len; j++)
        if (rd_got[j] !== resp(hdr_n + j)) begin nbad++; if (fb < 0) fb = j; end
      if (fb < 0) chk(rd_n == len, t, "read byte count", rd_n, len);
      else chk(0, t, "read byte mismatch", int'(rd_got[fb]), int'(resp(hdr_n + fb)));
    end
    chk(done_cnt - d0 == 1, "R11", "done cycles", done_cnt - d0, 1);
    chk(cb_cnt - cb0 == exp_cb, "R7", "CS fall under BUSY", cb_cnt - cb0, exp_cb);
    chk(db_cnt - db0 == exp_db, "R8", "done under BUSY", db_cnt - db0, exp_db);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0, d0;
    int lens [5] = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n && !spi_sclk && req_ready && !done && !rd_valid, "R1", "reset outputs",
        {spi_cs_n, spi_sclk, req_ready, done, rd_valid}, 5'b10100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep of kinds and lengths, alternating stream throttling
    for (int k = 0; k < 6; k++)
      for (int li = 0; li < 5; li++)
        run_txn(k, 1'b0, 8'(8'h10 + k * 17 + lens[li]),
                16'(16'hA000 + k * 16'h111 + lens[li]), lens[li], lens[li][0], 0, 0, 0);

    // R3 spare kind 7 frames as a command write
    run_txn(7, 1'b0, 8'h2B, 16'h0, 2, 1'b1, 0, 0, 0);

    // R12 read stalls with a pending byte
    run_txn(3, 1'b0, 8'h1D, 16'h0918, 3, 1'b0, 40, 0, 0);

    // R8 sleep opcode: done without the post BUSY wait
    run_txn(0, 1'b0, SLEEP_OP, 16'h0, 1, 1'b0, 0, 0, 1);
    repeat (20) @(negedge clk);

    // R7 frame held off while BUSY high
    hold = 1'b1;
    f0 = frames;
    fork
      run_txn(2, 1'b0, 8'h0D, 16'h08AC, 1, 1'b0, 0, 0, 0);
      begin
        repeat (50) @(negedge clk);
        chk(frames == f0 && spi_cs_n, "R7", "frame started under BUSY", frames - f0, 0);
        hold = 1'b0;
      end
    join

    // R10 flag has no effect on a command write
    hold = 1'b1;
    f0 = frames;
    fork
      run_txn(0, 1'b1, 8'h33, 16'h0, 2, 1'b0, 0, 0, 0);
      begin
        repeat (50) @(negedge clk);
        chk(frames == f0 && spi_cs_n, "R10", "nobusy honored on command", frames - f0, 0);
        hold = 1'b0;
      end
    join

    // R9 wake-up: no pre wait, post wait kept
    hold = 1'b1;
    f0 = frames; d0 = done_cnt;
    fork
      run_txn(6, 1'b0, 8'h55, 16'h0, 4, 1'b0, 0, 1, 0);
      begin
        repeat (120) @(negedge clk);
        chk(frames - f0 == 1 && done_cnt == d0, "R9", "wake frame sent, done held",
            frames - f0, 1);
        hold = 1'b0;
      end
    join

    // R10 register access with both waits skipped
    hold = 1'b1;
    run_txn(2, 1'b1, 8'h0D, 16'h0740, 2, 1'b0, 0, 1, 1);
    run_txn(3, 1'b1, 8'h1D, 16'h0741, 2, 1'b0, 0, 1, 1);
    hold = 1'b0;
    repeat (20) @(negedge clk);

    // R11 request offered while not ready is ignored
    f0 = frames;
    fork
      run_txn(1, 1'b0, 8'h17, 16'h0, 5, 1'b0, 0, 0, 0);
      begin
        repeat (8) @(negedge clk);
        req_kind = 3'd6; req_valid = 1'b1;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (100) @(negedge clk);
    chk(frames - f0 == 1 && req_ready, "R11", "frames after ignored request", frames - f0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule